// File: doc/BRIEF.md
# Charge Request Limiter with Command Watchdog

This block sits between a system-management register interface and the two converters that set a battery charger's current and voltage targets. Current requests arrive in milliamps and voltage requests in millivolts, each as a 16-bit word on its own valid/ready stream. Each accepted word is checked against a ceiling. A 2-bit current range selector picks the current ceiling, and a 3-bit voltage range selector picks the voltage ceiling. The word is cut down to the step size of the active range and then held on a registered converter code output. A per-channel over-range flag reports a request that reached or passed its ceiling. A zero current request is treated as a request to stop charging.

Both streams apply back-pressure only while reset is active. From the first clock edge after reset is released, both ready outputs stay high. A word is taken on every edge where valid and ready are both high. The two streams are independent, so a current word and a voltage word taken on the same edge are both applied. The range selectors are sampled on the edge that accepts the word.

A command watchdog counts clock ticks since the last accepted word on either stream. If the count reaches the parameter `WDOG_TICKS`, the block drops both converter codes to zero and raises a timeout flag. After reset, the block supplies a fixed 80 mA wake-up current until the first command arrives.

Top module: `chg_req_limiter`

## Requirements
- R1: A current word taken while `ilim_sel` is 0, 1, 2 or 3 is limited to 0x03FF, 0x07FE, 0x0BFC or 0x0FFC, in that order. The result appears on `cur_dac` after the accepting edge.
- R2: `cur_ovr` is set when the accepted current word is at least 0x0400, 0x0800, 0x0C00 or 0x1000 for `ilim_sel` 0, 1, 2 or 3. In that case `cur_dac` takes the ceiling from R1. Otherwise `cur_ovr` is cleared.
- R3: Below the ceiling, the current word keeps its full value for `ilim_sel`=0. Bit 0 is cleared for `ilim_sel`=1, and bits 1:0 are cleared for `ilim_sel`=2 or 3.
- R4: An accepted current word of zero gives `cur_dac`=0, clears `cur_ovr` and sets `chg_off`. An accepted non-zero current word clears `chg_off`.
- R5: Below the ceiling, an accepted voltage word has bits 3:0 cleared on `volt_dac`.
- R6: The voltage threshold for `vlim_sel` 0, 1, 2, 3 and 4 is 0x1090, 0x10D0, 0x1150, 0x11A0 and 0x1580 in turn. Codes 5 to 7 use 0x1580. A voltage word at or above the threshold gives `volt_dac` = threshold − 16 and sets `volt_ovr`. A word below the threshold clears `volt_ovr`.
- R7: After reset, `cur_dac` is 80, `volt_dac` is 0, and `cur_ovr`, `volt_ovr`, `chg_off` and `wdog_to` are all 0.
- R8: After `WDOG_TICKS` consecutive clock edges with no word accepted on either stream, the block sets `cur_dac` and `volt_dac` to 0, clears both over-range flags, and sets `chg_off` and `wdog_to`.
- R9: Any accepted word restarts the watchdog count and clears `wdog_to`. A run of `WDOG_TICKS`−1 idle edges does not trigger a timeout.
- R10: `cur_ready` and `volt_ready` are low during reset and high from the first edge after reset. The two streams are accepted independently, including on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_valid | input | 1 | Current word is offered |
| cur_ready | output | 1 | Current word can be taken |
| cur_word | input | 16 | Requested current in mA |
| volt_valid | input | 1 | Voltage word is offered |
| volt_ready | output | 1 | Voltage word can be taken |
| volt_word | input | 16 | Requested voltage in mV |
| ilim_sel | input | 2 | Current range selector |
| vlim_sel | input | 3 | Voltage range selector |
| cur_dac | output | 16 | Code for the current converter |
| volt_dac | output | 16 | Code for the voltage converter |
| cur_ovr | output | 1 | Last current word reached its ceiling |
| volt_ovr | output | 1 | Last voltage word reached its threshold |
| chg_off | output | 1 | Charging stopped by a zero request or a timeout |
| wdog_to | output | 1 | Command watchdog expired |

## Verification
The assertions assume three things about the inputs. Words and range selectors are stable whenever valid is high. Valid stays low while reset is active. `WDOG_TICKS` is at least 2. The stimulus respects all three by changing inputs only on falling clock edges and keeping both valid inputs low until reset is released. The bench uses a watchdog of 40 ticks so that idle gaps of exactly 39 and 40 edges can both be exercised. Words are aimed just below, at and above every ceiling, as well as at zero and full scale, for every range code.

// File: rtl/chg_lim_pkg.sv
package chg_lim_pkg;

  localparam int WORD_W    = 16;
  localparam int VOLT_DROP = 4;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t WAKE_CUR = word_t'(80);

  // Over-range threshold of the current channel per range code.
  function automatic word_t cur_thresh(input logic [1:0] code);
    case (code)
      2'd0:    return word_t'(16'h0400);
      2'd1:    return word_t'(16'h0800);
      2'd2:    return word_t'(16'h0C00);
      default: return word_t'(16'h1000);
    endcase
  endfunction

  // Number of low bits dropped for the current step size.
  function automatic logic [1:0] cur_drop(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // Over-range threshold of the voltage channel per range code.
  function automatic word_t volt_thresh(input logic [2:0] code);
    case (code)
      3'd0:    return word_t'(16'h1090);
      3'd1:    return word_t'(16'h10D0);
      3'd2:    return word_t'(16'h1150);
      3'd3:    return word_t'(16'h11A0);
      default: return word_t'(16'h1580);
    endcase
  endfunction

endpackage

// File: rtl/chg_cur_limiter.sv
module chg_cur_limiter
  import chg_lim_pkg::*;
(
  input  word_t       req_i,
  input  logic [1:0]  code_i,
  output word_t       cmd_o,
  output logic        ovr_o,
  output logic        zero_o
);

  word_t thr;
  word_t step;

  always_comb begin
    thr    = cur_thresh(code_i);
    step   = word_t'(1) << cur_drop(code_i);
    zero_o = (req_i == '0);
    ovr_o  = (req_i >= thr);
    if (ovr_o) begin
      cmd_o = thr - step;
    end else begin
      cmd_o = req_i & ~(step - word_t'(1));
    end
  end

endmodule

// File: rtl/chg_volt_limiter.sv
module chg_volt_limiter
  import chg_lim_pkg::*;
(
  input  word_t       req_i,
  input  logic [2:0]  code_i,
  output word_t       cmd_o,
  output logic        ovr_o
);

  localparam word_t STEP = word_t'(1) << VOLT_DROP;

  word_t thr;

  always_comb begin
    thr   = volt_thresh(code_i);
    ovr_o = (req_i >= thr);
    if (ovr_o) begin
      cmd_o = thr - STEP;
    end else begin
      cmd_o = req_i & ~(STEP - word_t'(1));
    end
  end

endmodule

// File: rtl/chg_wdog.sv
module chg_wdog #(
  parameter int unsigned TICKS = 2_000_000,
  localparam int CW = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic fire_o
);

  logic [CW-1:0] cnt_q;

  assign fire_o = !kick_i && (cnt_q == CW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (kick_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(TICKS)) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // R8
  wdog_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TICKS));

  // R8
  wdog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (cnt_q == CW'(TICKS)));

  // R9
  wdog_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == '0));

endmodule

// File: rtl/chg_req_limiter.sv
module chg_req_limiter
  import chg_lim_pkg::*;
#(
  parameter int unsigned WDOG_TICKS = 2_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cur_valid,
  output logic        cur_ready,
  input  logic [15:0] cur_word,
  input  logic        volt_valid,
  output logic        volt_ready,
  input  logic [15:0] volt_word,
  input  logic [1:0]  ilim_sel,
  input  logic [2:0]  vlim_sel,
  output logic [15:0] cur_dac,
  output logic [15:0] volt_dac,
  output logic        cur_ovr,
  output logic        volt_ovr,
  output logic        chg_off,
  output logic        wdog_to
);

  logic  rdy_q;
  logic  cur_acc, volt_acc, any_acc;
  word_t c_cmd, v_cmd;
  logic  c_ovr, c_zero, v_ovr;
  logic  wd_fire;
  word_t cur_q, volt_q;
  logic  cur_ovr_q, volt_ovr_q, off_q, to_q;

  assign cur_acc  = cur_valid  && rdy_q;
  assign volt_acc = volt_valid && rdy_q;
  assign any_acc  = cur_acc || volt_acc;

  chg_cur_limiter u_cur (
    .req_i  (cur_word),
    .code_i (ilim_sel),
    .cmd_o  (c_cmd),
    .ovr_o  (c_ovr),
    .zero_o (c_zero)
  );

  chg_volt_limiter u_volt (
    .req_i  (volt_word),
    .code_i (vlim_sel),
    .cmd_o  (v_cmd),
    .ovr_o  (v_ovr)
  );

  chg_wdog #(.TICKS(WDOG_TICKS)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick_i (any_acc),
    .fire_o (wd_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q      <= 1'b0;
      cur_q      <= WAKE_CUR;
      volt_q     <= '0;
      cur_ovr_q  <= 1'b0;
      volt_ovr_q <= 1'b0;
      off_q      <= 1'b0;
      to_q       <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (wd_fire) begin
        cur_q      <= '0;
        volt_q     <= '0;
        cur_ovr_q  <= 1'b0;
        volt_ovr_q <= 1'b0;
        off_q      <= 1'b1;
        to_q       <= 1'b1;
      end else begin
        if (cur_acc) begin
          cur_q     <= c_cmd;
          cur_ovr_q <= c_ovr;
          off_q     <= c_zero;
        end
        if (volt_acc) begin
          volt_q     <= v_cmd;
          volt_ovr_q <= v_ovr;
        end
        if (any_acc) begin
          to_q <= 1'b0;
        end
      end
    end
  end

  assign cur_ready  = rdy_q;
  assign volt_ready = rdy_q;
  assign cur_dac    = cur_q;
  assign volt_dac   = volt_q;
  assign cur_ovr    = cur_ovr_q;
  assign volt_ovr   = volt_ovr_q;
  assign chg_off    = off_q;
  assign wdog_to    = to_q;

  // R1
  cur_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_dac <= 16'h0FFC);

  // R2
  cur_ovr_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ovr |-> (cur_dac == 16'h03FF || cur_dac == 16'h07FE ||
                 cur_dac == 16'h0BFC || cur_dac == 16'h0FFC));

  // R3
  cur_step2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_dac > 16'h03FF) |-> !cur_dac[0]);

  // R3
  cur_step4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_dac > 16'h07FE) |-> (cur_dac[1:0] == 2'b00));

  // R4
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_off |-> (cur_dac == 16'h0000 && !cur_ovr));

  // R5
  volt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    volt_dac[3:0] == 4'h0);

  // R6
  volt_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    volt_dac < 16'h1580);

  // R8
  wdog_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_to |-> (cur_dac == 16'h0000 && volt_dac == 16'h0000 &&
                 !cur_ovr && !volt_ovr && chg_off));

  // R9
  wdog_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_to) |-> $past(!cur_valid && !volt_valid));

  // R10
  ready_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_ready == volt_ready);

endmodule

// File: tb/chg_req_limiter_tb.sv
module chg_req_limiter_tb_top;

  localparam int W = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cur_valid = 1'b0;
  logic        volt_valid = 1'b0;
  logic [15:0] cur_word = '0;
  logic [15:0] volt_word = '0;
  logic [1:0]  ilim_sel = '0;
  logic [2:0]  vlim_sel = '0;
  logic        cur_ready, volt_ready;
  logic [15:0] cur_dac, volt_dac;
  logic        cur_ovr, volt_ovr, chg_off, wdog_to;

  always #10ns clk = ~clk;

  chg_req_limiter #(.WDOG_TICKS(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cur_valid(cur_valid), .cur_ready(cur_ready), .cur_word(cur_word),
    .volt_valid(volt_valid), .volt_ready(volt_ready), .volt_word(volt_word),
    .ilim_sel(ilim_sel), .vlim_sel(vlim_sel),
    .cur_dac(cur_dac), .volt_dac(volt_dac),
    .cur_ovr(cur_ovr), .volt_ovr(volt_ovr),
    .chg_off(chg_off), .wdog_to(wdog_to)
  );

  int    errors = 0;
  int    checks = 0;
  string ph = "R7";

  // Reference model state
  int m_cur = 80, m_volt = 0, idle = 0;
  bit m_cov = 0, m_vov = 0, m_off = 0, m_to = 0, m_rdy = 0;

  function automatic int cur_thr(int code);  return 1024 * (code + 1); endfunction
  function automatic int cur_step(int code); return (code == 0) ? 1 : (code == 1) ? 2 : 4; endfunction
  function automatic int volt_thr(int code);
    case (code)
      0: return 'h1090;
      1: return 'h10D0;
      2: return 'h1150;
      3: return 'h11A0;
      default: return 'h1580;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cur = 80; m_volt = 0; m_cov = 0; m_vov = 0; m_off = 0; m_to = 0;
      m_rdy = 0; idle = 0;
    end else begin
      bit ca, va;
      ca = cur_valid && m_rdy;
      va = volt_valid && m_rdy;
      if (ca || va) begin
        idle = 0;
        m_to = 0;
        if (ca) begin
          int r, t, s;
          r = int'(cur_word); t = cur_thr(int'(ilim_sel)); s = cur_step(int'(ilim_sel));
          m_cov = (r >= t);
          m_cur = m_cov ? t - s : (r / s) * s;
          m_off = (r == 0);
        end
        if (va) begin
          int r, t;
          r = int'(volt_word); t = volt_thr(int'(vlim_sel));
          m_vov = (r >= t);
          m_volt = m_vov ? t - 16 : (r / 16) * 16;
        end
      end else if (idle < W) begin
        idle++;
        if (idle == W) begin
          m_cur = 0; m_volt = 0; m_cov = 0; m_vov = 0; m_off = 1; m_to = 1;
        end
      end
      m_rdy = 1;
    end
  end

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(ph,    "cur_dac",  int'(cur_dac),  m_cur);
    chk(ph,    "volt_dac", int'(volt_dac), m_volt);
    chk(ph,    "cur_ovr",  int'(cur_ovr),  int'(m_cov));
    chk(ph,    "volt_ovr", int'(volt_ovr), int'(m_vov));
    chk("R4",  "chg_off",  int'(chg_off),  int'(m_off));
    chk("R8",  "wdog_to",  int'(wdog_to),  int'(m_to));
    chk("R10", "cur_ready",  int'(cur_ready),  int'(m_rdy));
    chk("R10", "volt_ready", int'(volt_ready), int'(m_rdy));
  end

  task automatic put_cur(int d, int code);
    cur_valid = 1'b1; cur_word = 16'(d); ilim_sel = 2'(code);
    @(negedge clk);
    cur_valid = 1'b0;
  endtask

  task automatic put_volt(int d, int code);
    volt_valid = 1'b1; volt_word = 16'(d); vlim_sel = 3'(code);
    @(negedge clk);
    volt_valid = 1'b0;
  endtask

  task automatic idle_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 run hung: actual=running expected=done");
    finish_run();
  end

  initial begin
    ph = "R7";
    idle_n(3);
    rst_n = 1'b1;
    idle_n(3);
    ph = "R1";
    for (int c = 0; c < 4; c++) begin
      put_cur(16'hFFFF, c);
      put_cur(cur_thr(c) + 5, c);
    end
    ph = "R2";
    for (int c = 0; c < 4; c++) begin
      put_cur(cur_thr(c) - 1, c);
      put_cur(cur_thr(c), c);
      put_cur(cur_thr(c) + 1, c);
    end
    ph = "R3";
    for (int c = 0; c < 4; c++) begin
      put_cur(16'h0203, c);
      put_cur(16'h03FF, c);
      put_cur(1, c);
    end
    ph = "R4";
    put_cur(0, 3);
    put_cur(500, 1);
    put_cur(0, 0);
    put_volt(16'h0FFF, 2);
    put_cur(16'hFFFF, 0);
    ph = "R5";
    put_volt(16'h0EDF, 4);
    put_volt(16'h100F, 0);
    put_volt(16'h0001, 1);
    ph = "R6";
    for (int c = 0; c < 8; c++) begin
      put_volt(volt_thr(c) - 1, c);
      put_volt(volt_thr(c), c);
      put_volt(16'hFFFF, c);
    end
    ph = "R9";
    put_cur(1000, 2);
    idle_n(W - 1);
    put_volt(4200, 4);
    idle_n(W - 1);
    put_cur(1500, 3);
    ph = "R8";
    idle_n(W);
    idle_n(5);
    ph = "R9";
    put_volt(4100, 4);
    idle_n(2);
    put_cur(800, 1);
    ph = "R8";
    idle_n(W + 3);
    ph = "R10";
    cur_valid = 1'b1; volt_valid = 1'b1;
    cur_word = 16'h0C00; ilim_sel = 2'd3; volt_word = 16'h1200; vlim_sel = 3'd3;
    @(negedge clk);
    ilim_sel = 2'd0; vlim_sel = 3'd0;
    cur_valid = 1'b0; volt_valid = 1'b0;
    idle_n(2);
    for (int i = 0; i < 400; i++) begin
      cur_valid  = ($urandom_range(0, 2) == 0);
      volt_valid = ($urandom_range(0, 2) == 0);
      ilim_sel   = 2'($urandom_range(0, 3));
      vlim_sel   = 3'($urandom_range(0, 7));
      cur_word   = ($urandom_range(0, 3) == 0) ? 16'(cur_thr(int'(ilim_sel)) - 2 + $urandom_range(0, 3))
                                               : 16'($urandom_range(0, 16'hFFFF));
      volt_word  = ($urandom_range(0, 3) == 0) ? 16'(volt_thr(int'(vlim_sel)) - 2 + $urandom_range(0, 3))
                                               : 16'($urandom_range(0, 16'hFFFF));
      if (i % 97 == 0) begin
        cur_valid = 1'b0; volt_valid = 1'b0;
        idle_n(W + 2);
      end
      @(negedge clk);
    end
    cur_valid = 1'b0; volt_valid = 1'b0;
    idle_n(3);
    finish_run();
  end

endmodule